// File: doc/BRIEF.md
# Pause Control Frame Generator

This block builds one flow-control PAUSE frame, in the IEEE 802.3x format, each time the host asks for one. The host has a single 32-bit control word. It writes that word through a one-cycle write strobe and can read it back at any time. The upper half-word of the word holds a 16-bit pause quantum. Bit 0 is both the trigger and the status: writing it as 1 while the block is idle starts a frame, and reading it as 1 means a frame is still being sent.

The frame leaves as a byte stream with valid/ready flow control and start and end markers. The block sends the reserved multicast destination and the station's own source address. These are followed by the MAC-control type, the PAUSE opcode, the pause quantum and zero padding, for 60 bytes in all. The frame check sequence, preamble and inter-frame gap are added further down the transmit path. The pause quantum and the station address are latched when the frame starts, so neither can change while the frame is in flight.

Top module: `pause_frame_gen`

## Requirements
- R1: When `reg_wr_en` is high, `reg_wr_data[0]` is 1 and the block is idle, the block starts a frame. From the next cycle `tx_valid` is high, `tx_sof` is high and `tx_data` is 0x01.
- R2: The pause quantum is `reg_wr_data[31:16]` from the starting write. It goes out as byte 16 (high byte) and then byte 17 (low byte), with byte 0 being the first byte of the frame.
- R3: Bytes 0 to 5 are 01 80 C2 00 00 01. Bytes 6 to 11 are `stn_addr` with bits [47:40] first and bits [7:0] last. Bytes 12 and 13 are 0x88 and 0x08. Bytes 14 and 15 are 0x00 and 0x01.
- R4: Bytes 18 to 59 are 0x00 and the frame is exactly 60 bytes long. `tx_sof` is high only on byte 0 and `tx_eof` is high only on byte 59.
- R5: `reg_rd_data[0]` reads 1 from the cycle after the starting write. It stays 1 until byte 59 is accepted (`tx_valid` and `tx_ready` both high) and reads 0 from the next cycle on. `tx_valid` follows the same timing.
- R6: A write that arrives while `reg_rd_data[0]` is 1 is ignored. It changes neither `reg_rd_data[31:16]` nor any byte of the frame in flight, and it starts no second frame.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sof` and `tx_eof` hold their values into the next cycle.
- R8: A write with `reg_wr_data[0]` equal to 0 while idle stores `reg_wr_data[31:16]` as the pause quantum, readable on `reg_rd_data[31:16]`, and starts no frame.
- R9: While `rst` is high at a clock edge, the next cycle shows `tx_valid` low and `reg_rd_data` equal to 0. The next frame after reset begins again at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 32 | Write data: [31:16] pause quantum, [0] start |
| reg_rd_data | output | 32 | Read data: [31:16] pause quantum, [0] busy |
| stn_addr | input | 48 | Station address used as the source address |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |

## Verification
The starting write is registered, so the first byte and the busy bit appear one cycle after the write edge. Each later byte appears one cycle after the previous byte is accepted, and busy drops one cycle after the final byte is accepted. The bench drives inputs and samples outputs on the falling edge. It records a byte only in a cycle where valid and its own ready are both high, and it compares stalled cycles against the value held on the previous falling edge. The busy and reset checks are made at the first falling edge after the edge that is meant to change them.

// File: rtl/pause_frame_gen.sv
module pause_frame_gen #(
  parameter int          PT_W        = 16,
  parameter int          FRAME_BYTES = 60,
  parameter logic [47:0] DEST_ADDR   = 48'h0180C2000001,
  parameter logic [15:0] CTRL_TYPE   = 16'h8808,
  parameter logic [15:0] PAUSE_OP    = 16'h0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  input  logic [47:0] stn_addr,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_sof,
  output logic        tx_eof
);

  localparam int IDX_W    = $clog2(FRAME_BYTES);
  localparam int LAST_IDX = FRAME_BYTES - 1;
  localparam int PT_LSB   = 32 - PT_W;

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [PT_W-1:0]  pt_q;
  logic [47:0]      sa_q;
  logic [7:0]       byte_c;
  logic             accept;
  logic             last;
  int               k;

  assign accept = busy_q && tx_ready;
  assign last   = (int'(idx_q) == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      pt_q   <= '0;
      sa_q   <= '0;
    end else if (!busy_q) begin
      if (reg_wr_en) begin
        pt_q <= reg_wr_data[31:PT_LSB];
        if (reg_wr_data[0]) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          sa_q   <= stn_addr;
        end
      end
    end else if (accept) begin
      if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    k      = int'(idx_q);
    byte_c = 8'h00;
    if (k < 6)
      byte_c = 8'(DEST_ADDR >> (8 * (5 - k)));
    else if (k < 12)
      byte_c = 8'(sa_q >> (8 * (11 - k)));
    else if (k == 12)
      byte_c = CTRL_TYPE[15:8];
    else if (k == 13)
      byte_c = CTRL_TYPE[7:0];
    else if (k == 14)
      byte_c = PAUSE_OP[15:8];
    else if (k == 15)
      byte_c = PAUSE_OP[7:0];
    else if (k == 16)
      byte_c = 8'(pt_q >> 8);
    else if (k == 17)
      byte_c = pt_q[7:0];
  end

  assign tx_data     = byte_c;
  assign tx_valid    = busy_q;
  assign tx_sof      = busy_q && (idx_q == '0);
  assign tx_eof      = busy_q && last;
  assign reg_rd_data = {pt_q, {(PT_LSB-1){1'b0}}, busy_q};

endmodule

module pause_frame_gen_props (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr_en,
  input logic [31:0] reg_wr_data,
  input logic [31:0] reg_rd_data,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_sof,
  input logic        tx_eof
);

  logic [7:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      acc_cnt <= '0;
    else if (tx_valid && tx_ready)
      acc_cnt <= tx_eof ? 8'd0 : acc_cnt + 8'd1;
  end

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_data[0] && reg_wr_en && reg_wr_data[0] |=> tx_valid && tx_sof);

  p_eof_position_r4: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready && tx_eof |-> acc_cnt == 8'd59);

  p_markers_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_sof || tx_eof) |-> tx_valid && $onehot0({tx_sof, tx_eof}));

  p_busy_clear_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready && tx_eof |=> !reg_rd_data[0]);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[0] && !(tx_ready && tx_eof) |=> reg_rd_data[0]);

  p_time_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[0] && reg_wr_en |=> $stable(reg_rd_data[31:16]));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

  p_no_start_r8: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_data[0] && reg_wr_en && !reg_wr_data[0] |=> !tx_valid);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> !tx_valid && reg_rd_data == 32'd0);

endmodule

bind pause_frame_gen pause_frame_gen_props u_props (.*);

// File: tb/pause_frame_gen_test.sv
module pause_frame_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [47:0] stn_addr = 48'hA1B2C3D4E5F6;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        tx_sof;
  logic        tx_eof;

  int errors = 0;
  int checks = 0;
  logic [7:0] got [60];
  bit gsof [60];
  bit geof [60];
  int ngot;

  pause_frame_gen uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i, input logic [47:0] sa, input logic [15:0] pt);
    logic [47:0] da = 48'h0180C2000001;
    if (i < 6) return 8'(da >> (8 * (5 - i)));
    if (i < 12) return 8'(sa >> (8 * (11 - i)));
    case (i)
      12: return 8'h88;
      13: return 8'h08;
      14: return 8'h00;
      15: return 8'h01;
      16: return pt[15:8];
      17: return pt[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic reg_write(input logic [31:0] d);
    reg_wr_en = 1'b1;
    reg_wr_data = d;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic collect(input int mode, input bit inject);
    int cyc = 0;
    bit done = 0;
    bit stalled = 0;
    logic [7:0] pd = '0;
    bit ps = 0, pe = 0;
    ngot = 0;
    while (!done && cyc < 1000) begin
      tx_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (inject) begin
        reg_wr_en = (cyc == 7);
        reg_wr_data = 32'hAAAA0001;
      end
      if (stalled) begin
        chk(tx_valid && tx_data == pd && tx_sof == ps && tx_eof == pe,
            "R7", "held byte during stall", tx_data, pd);
        if (inject && cyc == 8)
          chk(reg_rd_data[31:16] != 16'hAAAA, "R6", "pause time after busy write", reg_rd_data[31:16], 0);
      end
      stalled = 0;
      if (tx_valid && tx_ready) begin
        if (ngot < 60) begin
          got[ngot] = tx_data; gsof[ngot] = tx_sof; geof[ngot] = tx_eof;
        end
        ngot++;
        if (tx_eof) done = 1;
      end else if (tx_valid) begin
        stalled = 1; pd = tx_data; ps = tx_sof; pe = tx_eof;
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    reg_wr_en = 1'b0;
    tx_ready = 1'b0;
    chk(reg_rd_data[0] == 1'b0, "R5", "busy after last byte", reg_rd_data[0], 0);
    chk(tx_valid == 1'b0, "R5", "valid after last byte", tx_valid, 0);
  endtask

  task automatic compare_frame(input logic [47:0] sa, input logic [15:0] pt);
    chk(ngot == 60, "R4", "frame length", ngot, 60);
    for (int i = 0; i < 60 && i < ngot; i++) begin
      logic [7:0] e = exp_byte(i, sa, pt);
      if (i < 16) chk(got[i] == e, "R3", $sformatf("header byte %0d", i), got[i], e);
      else if (i < 18) chk(got[i] == e, "R2", $sformatf("pause byte %0d", i), got[i], e);
      else chk(got[i] == e, "R4", $sformatf("pad byte %0d", i), got[i], e);
      chk(gsof[i] == (i == 0), "R4", $sformatf("sof at byte %0d", i), gsof[i], i == 0);
      chk(geof[i] == (i == 59), "R4", $sformatf("eof at byte %0d", i), geof[i], i == 59);
    end
  endtask

  task automatic t_reset;
    chk(tx_valid == 1'b0, "R9", "valid after reset", tx_valid, 0);
    chk(reg_rd_data == 32'd0, "R9", "read data after reset", reg_rd_data, 0);
  endtask

  task automatic t_basic;
    reg_write(32'h12340001);
    chk(tx_valid && tx_sof && tx_data == 8'h01, "R1", "first byte after start", tx_data, 8'h01);
    chk(reg_rd_data[0] == 1'b1, "R5", "busy during frame", reg_rd_data[0], 1);
    chk(reg_rd_data[31:16] == 16'h1234, "R2", "pause time readback", reg_rd_data[31:16], 16'h1234);
    collect(0, 0);
    compare_frame(48'hA1B2C3D4E5F6, 16'h1234);
  endtask

  task automatic t_backpressure;
    stn_addr = 48'h0C0FFEE12345;
    reg_write(32'h00FF0001);
    stn_addr = 48'hFFFFFFFFFFFF;
    collect(1, 1);
    compare_frame(48'h0C0FFEE12345, 16'h00FF);
    chk(reg_rd_data[31:16] == 16'h00FF, "R6", "pause time kept after busy write", reg_rd_data[31:16], 16'h00FF);
  endtask

  task automatic t_nostart;
    reg_write(32'hBEEF0000);
    repeat (4) @(negedge clk);
    chk(tx_valid == 1'b0, "R8", "no frame without start bit", tx_valid, 0);
    chk(reg_rd_data == 32'hBEEF0000, "R8", "stored pause time", reg_rd_data, 32'hBEEF0000);
    stn_addr = 48'h001122334455;
    reg_write(32'hBEEF0001);
    collect(0, 0);
    compare_frame(48'h001122334455, 16'hBEEF);
  endtask

  task automatic t_reset_mid;
    reg_write(32'h55AA0001);
    tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    tx_ready = 1'b0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk(tx_valid == 1'b0, "R9", "valid after mid-frame reset", tx_valid, 0);
    chk(reg_rd_data == 32'd0, "R9", "read data after mid-frame reset", reg_rd_data, 0);
    reg_write(32'h07080001);
    chk(tx_sof == 1'b1, "R9", "new frame restarts at byte 0", tx_sof, 1);
    collect(0, 0);
    compare_frame(48'h001122334455, 16'h0708);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_backpressure();
    t_nostart();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule